// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block takes a three-wire serial audio stream (bit clock, frame clock, data) and turns it into parallel samples in the system clock domain. The bit clock and frame clock are not used as clocks. They are brought through two-flop synchronizers, and a rising bit-clock transition is detected as a one-cycle strobe. That strobe advances one shared 32-bit shift-and-count engine. A static configuration picks the framing: I2S, left-justified, right-justified or a TDM daisy chain of `PAIRS` stereo pairs, where one chosen pair is extracted.

Each 32-bit subframe carries a sample of 16 to 24 bits, MSB first, plus 8 side bits. When a subframe completes, the block pulses `valid_o` for one cycle. With that pulse it presents:
- the sample, left-aligned in 24 bits;
- the 8 side bits;
- the slot index.

If a frame-clock edge arrives earlier than the bit count expects, the block drops the partial subframe, pulses `frame_err_o` and realigns to that edge.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and after its release, before any subframe completes, `valid_o` and `frame_err_o` are low and `sample_o`, `side_o` and `slot_o` are zero.
- R2: With `mode_i`=0 (I2S), the subframe MSB is sampled one bit clock after the bit at which the frame clock changed. A low frame clock marks the left channel (slot 0) and a high one the right channel (slot 1). Each subframe is 32 bits.
- R3: With `mode_i`=1 (left-justified), the MSB is sampled at the bit where the frame clock changed. High marks left (slot 0) and low marks right (slot 1).
- R4: With `mode_i`=2 (right-justified), framing is as in R3. The sample is the last `width_i` bits of the subframe, and `side_o` is the first 8 bits, in arrival order with the first-received bit in `side_o[7]`.
- R5: In modes 0, 1 and 3, the sample is the first `width_i` bits of the subframe. It is placed with the first-received bit in `sample_o[23]`, and the low 24-`width_i` bits are zero. `side_o` is the last 8 bits of the subframe, with the first of them in `side_o[7]`.
- R6: With `mode_i`=3 (TDM), a rising frame-clock edge marks the MSB of slot 0. Slots 0 to 2·`PAIRS`−1 follow back to back, 32 bits each, with even slots left. A falling frame-clock edge has no effect.
- R7: In TDM, `valid_o` fires only for slots 2·`pair_sel_i` and 2·`pair_sel_i`+1.
- R8: Every accepted completed subframe gives exactly one one-cycle `valid_o` pulse, with `slot_o` holding its slot index.
- R9: A frame-clock edge before 32 bits of a subframe (or, in TDM, before all 2·`PAIRS` slots) gives a one-cycle `frame_err_o` pulse. The partial subframe is dropped, and a new subframe starts at that edge.
- R10: Bits received after reset before the first frame-clock edge produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock, at most clk/4 |
| fclk_i | input | 1 | Serial frame clock |
| sdata_i | input | 1 | Serial data |
| mode_i | input | 2 | Framing: 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| width_i | input | 5 | Sample width in bits, 16 to 24 |
| pair_sel_i | input | PAIR_W | TDM stereo pair to extract |
| valid_o | output | 1 | One-cycle strobe per delivered subframe |
| sample_o | output | 24 | Sample, left-aligned |
| side_o | output | 8 | Side bits of the subframe |
| slot_o | output | SLOT_W | Channel or TDM slot index |
| frame_err_o | output | 1 | One-cycle early-edge framing error |

## Verification
The bench builds the block with `PAIRS`=4, so a TDM frame holds eight slots. This makes the last-slot wrap, the ignored mid-frame falling edge and the selection of a middle, first and last pair all reachable. The bench sends random subframe words in every framing at several widths, including 16, 20 and 24. It also sends an early edge in left-justified mode and a short TDM frame, and checks the error pulse and the realignment that follows.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  localparam int SUB_BITS  = 32;
  localparam int SIDE_BITS = 8;
  localparam int OUT_BITS  = 24;
  localparam int CNT_W     = $clog2(SUB_BITS);
endpackage

// File: rtl/srx_bit_sync.sv
module srx_bit_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic fclk_i,
  input  logic sdata_i,
  output logic bit_stb_o,
  output logic fclk_o,
  output logic data_o,
  output logic fedge_o
);
  logic [2:0] meta_q, sync_q;
  logic       bclk_d_q, fprev_q, primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_q   <= '0;
      bclk_d_q <= 1'b0;
    end else begin
      meta_q   <= {sdata_i, fclk_i, bclk_i};
      sync_q   <= meta_q;
      bclk_d_q <= sync_q[0];
    end
  end

  assign bit_stb_o = sync_q[0] & ~bclk_d_q;
  assign fclk_o    = sync_q[1];
  assign data_o    = sync_q[2];

  // frame-clock level remembered per bit; edges count only after first bit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fprev_q  <= 1'b0;
      primed_q <= 1'b0;
    end else if (bit_stb_o) begin
      fprev_q  <= sync_q[1];
      primed_q <= 1'b1;
    end
  end

  assign fedge_o = bit_stb_o & primed_q & (sync_q[1] ^ fprev_q);

  AST_STB_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb_o |=> !bit_stb_o); // R8
endmodule

// File: rtl/srx_frame_track.sv
module srx_frame_track
  import serial_rx_pkg::*;
#(
  parameter int PAIRS  = 4,
  parameter int SLOT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fmt_e              fmt_i,
  input  logic              bit_stb_i,
  input  logic              fclk_i,
  input  logic              data_i,
  input  logic              fedge_i,
  output logic              done_o,
  output logic [SUB_BITS-1:0] word_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              err_o
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(2 * PAIRS - 1);
  localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(SUB_BITS - 1);

  logic                  edge_dly_q, edge_dly_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic                  locked_q, locked_d;
  logic [SUB_BITS-2:0]   shreg_q, shreg_d;
  logic [SLOT_W-1:0]     slot_q, slot_d, slot_out_q, slot_out_d;
  logic [SUB_BITS-1:0]   word_q, word_d;
  logic                  done_q, done_d, err_q, err_d;
  logic                  tdm, align, chan;

  assign tdm  = (fmt_i == FMT_TDM);
  assign chan = (fmt_i == FMT_I2S) ? fclk_i : ~fclk_i;

  always_comb begin
    unique case (fmt_i)
      FMT_I2S: align = bit_stb_i & edge_dly_q;
      FMT_TDM: align = fedge_i & fclk_i;
      default: align = fedge_i;
    endcase
  end

  always_comb begin
    edge_dly_d = edge_dly_q;
    cnt_d      = cnt_q;
    locked_d   = locked_q;
    shreg_d    = shreg_q;
    slot_d     = slot_q;
    slot_out_d = slot_out_q;
    word_d     = word_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    if (bit_stb_i) begin
      edge_dly_d = fedge_i;
      if (align) begin
        err_d    = locked_q & ((cnt_q != '0) | (tdm & (slot_q != '0)));
        locked_d = 1'b1;
        cnt_d    = CNT_W'(1);
        shreg_d  = {{(SUB_BITS-2){1'b0}}, data_i};
        slot_d   = tdm ? '0 : SLOT_W'(chan);
      end else if (locked_q) begin
        if (cnt_q == LAST_BIT) begin
          done_d     = 1'b1;
          word_d     = {shreg_q, data_i};
          slot_out_d = slot_q;
          cnt_d      = '0;
          if (tdm && (slot_q != LAST_SLOT)) slot_d = slot_q + SLOT_W'(1);
          else locked_d = 1'b0;
        end else begin
          shreg_d = {shreg_q[SUB_BITS-3:0], data_i};
          cnt_d   = cnt_q + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_dly_q <= 1'b0;
      cnt_q      <= '0;
      locked_q   <= 1'b0;
      shreg_q    <= '0;
      slot_q     <= '0;
      slot_out_q <= '0;
      word_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      edge_dly_q <= edge_dly_d;
      cnt_q      <= cnt_d;
      locked_q   <= locked_d;
      shreg_q    <= shreg_d;
      slot_q     <= slot_d;
      slot_out_q <= slot_out_d;
      word_q     <= word_d;
      done_q     <= done_d;
      err_q      <= err_d;
    end
  end

  assign done_o = done_q;
  assign word_o = word_q;
  assign slot_o = slot_out_q;
  assign err_o  = err_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_ERR_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (locked_q && cnt_q == CNT_W'(1))); // R9
  AST_TDM_SLOT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && tdm) |-> (slot_q <= LAST_SLOT)); // R6
endmodule

// File: rtl/srx_format.sv
module srx_format
  import serial_rx_pkg::*;
(
  input  fmt_e                 fmt_i,
  input  logic [4:0]           width_i,
  input  logic [SUB_BITS-1:0]  word_i,
  output logic [OUT_BITS-1:0]  sample_o,
  output logic [SIDE_BITS-1:0] side_o
);
  logic [OUT_BITS-1:0] keep_mask;
  logic                rj;

  assign rj        = (fmt_i == FMT_RJ);
  assign keep_mask = ~({OUT_BITS{1'b1}} >> width_i);

  always_comb begin
    if (rj) begin
      sample_o = (word_i[OUT_BITS-1:0] << (5'd24 - width_i)) & keep_mask;
      side_o   = word_i[SUB_BITS-1 -: SIDE_BITS];
    end else begin
      sample_o = word_i[SUB_BITS-1 -: OUT_BITS] & keep_mask;
      side_o   = word_i[SIDE_BITS-1:0];
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_rx_pkg::*;
#(
  parameter int PAIRS  = 4,
  parameter int SLOT_W = $clog2(2 * PAIRS),
  parameter int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              fclk_i,
  input  logic              sdata_i,
  input  logic [1:0]        mode_i,
  input  logic [4:0]        width_i,
  input  logic [PAIR_W-1:0] pair_sel_i,
  output logic              valid_o,
  output logic [23:0]       sample_o,
  output logic [7:0]        side_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              frame_err_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  fmt_e fmt;
  assign fmt = fmt_e'(mode_i);

  logic                  bit_stb, fclk_s, data_s, fedge;
  logic                  trk_done, trk_err;
  logic [SUB_BITS-1:0]   trk_word;
  logic [SLOT_W-1:0]     trk_slot;
  logic [OUT_BITS-1:0]   fmt_sample;
  logic [SIDE_BITS-1:0]  fmt_side;
  logic                  keep;

  srx_bit_sync u_sync (
    .clk(clk), .rst_n(rst_int_n), .bclk_i(bclk_i), .fclk_i(fclk_i),
    .sdata_i(sdata_i), .bit_stb_o(bit_stb), .fclk_o(fclk_s),
    .data_o(data_s), .fedge_o(fedge)
  );

  srx_frame_track #(.PAIRS(PAIRS), .SLOT_W(SLOT_W)) u_track (
    .clk(clk), .rst_n(rst_int_n), .fmt_i(fmt), .bit_stb_i(bit_stb),
    .fclk_i(fclk_s), .data_i(data_s), .fedge_i(fedge),
    .done_o(trk_done), .word_o(trk_word), .slot_o(trk_slot), .err_o(trk_err)
  );

  srx_format u_fmt (
    .fmt_i(fmt), .width_i(width_i), .word_i(trk_word),
    .sample_o(fmt_sample), .side_o(fmt_side)
  );

  assign keep = (fmt != FMT_TDM) || (PAIR_W'(trk_slot >> 1) == pair_sel_i);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_o  <= 1'b0;
      sample_o <= '0;
      side_o   <= '0;
      slot_o   <= '0;
    end else if (trk_done && keep) begin
      valid_o  <= 1'b1;
      sample_o <= fmt_sample;
      side_o   <= fmt_side;
      slot_o   <= trk_slot;
    end else begin
      valid_o  <= 1'b0;
    end
  end

  assign frame_err_o = trk_err;

  AST_STEREO_SLOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && fmt != FMT_TDM) |-> (slot_o <= SLOT_W'(1))); // R2
  AST_PAIR_FILTER: assert property (@(posedge clk) disable iff (!rst_int_n)
    (valid_o && fmt == FMT_TDM) |-> (PAIR_W'(slot_o >> 1) == pair_sel_i)); // R7
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_o |-> ((sample_o & (24'hFF_FFFF >> width_i)) == 24'h0)); // R5
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |=> (!valid_o && !frame_err_o)); // R1
endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  localparam int PAIRS  = 4;
  localparam int SLOT_W = 3;
  localparam int PAIR_W = 2;

  logic clk = 1'b0;
  logic rst_n, bclk, fclk, sdata;
  logic [1:0] mode;
  logic [4:0] width;
  logic [PAIR_W-1:0] pair;
  logic valid_o, frame_err_o;
  logic [23:0] sample_o;
  logic [7:0] side_o;
  logic [SLOT_W-1:0] slot_o;

  always #2.5 clk = ~clk;

  serial_audio_rx #(.PAIRS(PAIRS)) uut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fclk_i(fclk), .sdata_i(sdata),
    .mode_i(mode), .width_i(width), .pair_sel_i(pair), .valid_o(valid_o),
    .sample_o(sample_o), .side_o(side_o), .slot_o(slot_o),
    .frame_err_o(frame_err_o)
  );

  int total = 0, bad = 0;
  int nobs, nexp, nerr;
  logic [23:0] obs_s [64], exp_s [64];
  logic [7:0]  obs_d [64], exp_d [64];
  logic [SLOT_W-1:0] obs_k [64], exp_k [64];
  logic pend;
  bit done_flag = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && nobs < 64) begin
        obs_s[nobs] = sample_o; obs_d[nobs] = side_o; obs_k[nobs] = slot_o;
        nobs++;
      end
      if (frame_err_o) nerr++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
    end
  endtask

  function automatic logic [23:0] ref_sample(input logic [31:0] w);
    logic [23:0] r = '0;
    for (int k = 0; k < int'(width); k++)
      r[23-k] = (mode == 2'd2) ? w[int'(width)-1-k] : w[31-k];
    return r;
  endfunction

  function automatic logic [7:0] ref_side(input logic [31:0] w);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[7-k] = (mode == 2'd2) ? w[31-k] : w[7-k];
    return r;
  endfunction

  task automatic want(input logic [31:0] w, input int slot);
    exp_s[nexp] = ref_sample(w); exp_d[nexp] = ref_side(w);
    exp_k[nexp] = SLOT_W'(slot); nexp++;
  endtask

  task automatic put_bit(input logic f, input logic b);
    logic d;
    if (mode == 2'd0) begin d = pend; pend = b; end else d = b;
    @(negedge clk); bclk = 1'b0; fclk = f; sdata = d;
    repeat (3) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_sub(input logic f, input logic [31:0] w, input int nbits);
    for (int i = 31; i > 31 - nbits; i--) put_bit(f, w[i]);
  endtask

  task automatic start(input logic [1:0] m, input logic [4:0] wd, input logic [PAIR_W-1:0] p, input logic idle_f);
    rst_n = 1'b0; mode = m; width = wd; pair = p; bclk = 1'b0; fclk = idle_f; sdata = 1'b0;
    pend = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    nobs = 0; nexp = 0; nerr = 0;
    repeat (4) @(negedge clk);
    // R10: junk bits before the first frame-clock edge
    for (int i = 0; i < 3; i++) put_bit(idle_f, 1'($urandom));
  endtask

  task automatic finish_case(input string req, input int errs_expected);
    repeat (20) @(negedge clk);
    chk(nobs == nexp, {req, " count"}, nobs, nexp);
    for (int i = 0; i < nexp && i < nobs; i++) begin
      chk(obs_s[i] == exp_s[i], {req, " sample"}, obs_s[i], exp_s[i]);
      chk(obs_d[i] == exp_d[i], {req, " side"}, obs_d[i], exp_d[i]);
      chk(obs_k[i] == exp_k[i], {req, " slot R8"}, obs_k[i], exp_k[i]);
    end
    chk(nerr == errs_expected, {req, " frame_err R9"}, nerr, errs_expected);
  endtask

  task automatic stereo_case(input logic [1:0] m, input logic [4:0] wd, input string req);
    logic left_lvl;
    logic [31:0] w;
    left_lvl = (m == 2'd0) ? 1'b0 : 1'b1;
    start(m, wd, '0, ~left_lvl);
    for (int f = 0; f < 3; f++) begin
      w = $urandom; send_sub(left_lvl, w, 32); want(w, 0);
      w = $urandom; send_sub(~left_lvl, w, 32); want(w, 1);
    end
    put_bit(left_lvl, 1'b0);
    finish_case(req, 0);
  endtask

  task automatic tdm_case(input logic [PAIR_W-1:0] p, input logic [4:0] wd, input string req);
    logic [31:0] w;
    start(2'd3, wd, p, 1'b0);
    for (int f = 0; f < 2; f++)
      for (int s = 0; s < 2 * PAIRS; s++) begin
        w = $urandom;
        // R6: the frame clock falls at mid frame, which must be ignored
        send_sub((s < PAIRS) ? 1'b1 : 1'b0, w, 32);
        if ((s >> 1) == int'(p)) want(w, s);
      end
    put_bit(1'b1, 1'b0);
    finish_case(req, 0);
  endtask

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_0A17));
    rst_n = 1'b0; bclk = 1'b0; fclk = 1'b0; sdata = 1'b0;
    mode = 2'd1; width = 5'd24; pair = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(valid_o == 1'b0, "R1 valid", valid_o, 0);
    chk(frame_err_o == 1'b0, "R1 err", frame_err_o, 0);
    chk(sample_o == 24'h0, "R1 sample", sample_o, 0);
    chk(side_o == 8'h0, "R1 side", side_o, 0);
    chk(slot_o == '0, "R1 slot", slot_o, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(valid_o == 1'b0 && frame_err_o == 1'b0, "R1 after release", {valid_o, frame_err_o}, 0);

    stereo_case(2'd0, 5'd24, "R2 I2S w24");
    stereo_case(2'd0, 5'd16, "R2 R5 I2S w16");
    stereo_case(2'd1, 5'd20, "R3 R5 LJ w20");
    stereo_case(2'd2, 5'd16, "R4 RJ w16");
    stereo_case(2'd2, 5'd24, "R4 RJ w24");

    tdm_case(2'd2, 5'd18, "R6 R7 TDM pair2");
    tdm_case(2'd0, 5'd24, "R7 TDM pair0");
    tdm_case(2'd3, 5'd16, "R7 TDM pair3");

    // R9: early edge in left-justified mode
    start(2'd1, 5'd24, '0, 1'b0);
    w = $urandom; send_sub(1'b1, w, 32); want(w, 0);
    w = $urandom; send_sub(1'b0, w, 20);
    w = $urandom; send_sub(1'b1, w, 32); want(w, 0);
    w = $urandom; send_sub(1'b0, w, 32); want(w, 1);
    put_bit(1'b1, 1'b0);
    finish_case("R9 LJ early edge", 1);

    // R9: short TDM frame (three slots, then a new rising edge)
    start(2'd3, 5'd24, 2'd0, 1'b0);
    w = $urandom; send_sub(1'b1, w, 32); want(w, 0);
    w = $urandom; send_sub(1'b1, w, 32); want(w, 1);
    w = $urandom; send_sub(1'b0, w, 32);
    for (int s = 0; s < 2 * PAIRS; s++) begin
      w = $urandom; send_sub((s < PAIRS) ? 1'b1 : 1'b0, w, 32);
      if (s < 2) want(w, s);
    end
    put_bit(1'b1, 1'b0);
    finish_case("R9 TDM short frame", 1);

    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done_flag) begin
      total++; bad++;
      $display("FAIL watchdog R8 actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule